// File: doc/BRIEF.md
# Shift/Load Register with Parity and Zero Status

This block is a wide storage register driven by two one-hot command inputs. One command captures a parallel input word; the other moves the held value one place toward the most significant end, with a zero entering at the bottom. When neither command is active at a rising clock edge, the register keeps its contents. An active-low asynchronous clear sets every bit to zero at once, whatever the clock is doing.

Two status flags are decoded from the held value alone. One flag is high when the value contains an odd count of ones. The other flag is high when every bit is zero. Both flags are purely combinational from the stored value, so they change only after the stored value changes. The controlling logic must never raise both commands in the same cycle. That combination is a don't-care, and the design uses it to simplify its next-state logic.

Top module: `shload_reg`

## Requirements
- R1: While clr_n is low, the stored value q is all zeros. This holds asynchronously, even without a clock edge.
- R2: At a rising clock edge with do_load=0 and do_shift=0, q keeps its value.
- R3: At a rising clock edge with do_load=1 and do_shift=0, q takes the value of d_in.
- R4: At a rising clock edge with do_shift=1 and do_load=0, q becomes {q[WIDTH-2:0], 1'b0}. Bit 0 is filled with zero and the old top bit is lost.
- R5: par_odd is 1 exactly when q has an odd number of 1 bits, and 0 otherwise.
- R6: all_zero is 1 exactly when every bit of q is 0.
- R7: Both flags depend only on the current q. They do not change while q is stable, whatever d_in and the command inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| do_load | input | 1 | Load command (one-hot with do_shift) |
| do_shift | input | 1 | Shift-left command (one-hot with do_load) |
| d_in | input | WIDTH | Parallel data word |
| q | output | WIDTH | Stored value |
| par_odd | output | 1 | Odd parity of q |
| all_zero | output | 1 | q is all zeros |

## Verification
The load path is tested with these words:
- All ones, which gives even parity at full width.
- A single one in the top bit, which gives odd parity.
- Alternating patterns, which expose swapped bit lanes.
- Random words.

Repeated shifts walk a one up and out of the top bit, so the zero fill at the bottom, the discarded top bit and the transition of both flags are all exercised. Hold cycles change d_in freely to show that the inputs are ignored. A clear is applied in the middle of a cycle and sampled before the next edge, which separates an asynchronous clear from a synchronous one.

// File: rtl/shload_pkg.sv
package shload_pkg;
  typedef enum logic [1:0] {OP_HOLD = 2'b00, OP_LOAD = 2'b01, OP_SHIFT = 2'b10} op_e;

  function automatic logic odd_parity(input logic [63:0] v, input int unsigned w);
    logic p;
    p = 1'b0;
    for (int unsigned i = 0; i < 64; i++)
      if (i < w) p = p ^ v[i];
    return p;
  endfunction
endpackage

// File: rtl/shload_next.sv
module shload_next #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] d_in,
  input  logic             do_load,
  input  logic             do_shift,
  output logic [WIDTH-1:0] nxt
);
  // Both-high is a don't-care: shift takes priority, so no decode of the pair is needed.
  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic from_below;
    if (i == 0) begin : g_lsb
      assign from_below = 1'b0;
    end else begin : g_mid
      assign from_below = cur[i-1];
    end
    assign nxt[i] = do_shift ? from_below : (do_load ? d_in[i] : cur[i]);
  end
endmodule

// File: rtl/shload_status.sv
module shload_status #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] val,
  output logic             odd,
  output logic             zero
);
  assign odd  = ^val;
  assign zero = ~|val;
endmodule

// File: rtl/shload_reg.sv
module shload_reg #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             do_load,
  input  logic             do_shift,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q,
  output logic             par_odd,
  output logic             all_zero
);
  import shload_pkg::*;
  localparam logic [WIDTH-1:0] ZERO_W = '0;

  logic [WIDTH-1:0] q_next;
  op_e              cmd;

  assign cmd = do_shift ? OP_SHIFT : (do_load ? OP_LOAD : OP_HOLD);

  shload_next #(.WIDTH(WIDTH)) u_next (
    .cur(q), .d_in(d_in), .do_load(do_load), .do_shift(do_shift), .nxt(q_next)
  );

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= ZERO_W;
    else        q <= q_next;
  end

  shload_status #(.WIDTH(WIDTH)) u_stat (.val(q), .odd(par_odd), .zero(all_zero));

  // Checks sampled at the clock edge, disabled during clear.
  assert_cleared_R1: assert property (@(posedge clk) !clr_n |-> (q == ZERO_W));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!clr_n)
    (cmd == OP_HOLD) |=> $stable(q));
  assert_load_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (cmd == OP_LOAD) |=> (q == $past(d_in)));
  assert_shift_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (cmd == OP_SHIFT) |=> (q == {$past(q[WIDTH-2:0]), 1'b0}));
  assert_parity_R5: assert property (@(posedge clk) disable iff (!clr_n)
    par_odd == odd_parity(64'(q), WIDTH));
  assert_zero_R6: assert property (@(posedge clk) disable iff (!clr_n)
    all_zero == ($countones(q) == 0));
  assert_flags_stable_R7: assert property (@(posedge clk) disable iff (!clr_n)
    $stable(q) |-> ($stable(par_odd) && $stable(all_zero)));
endmodule

// File: tb/shload_reg_test.sv
module shload_reg_test;
  localparam int W = 64;
  logic clk = 1'b0;
  logic clr_n = 1'b0;
  logic do_load = 1'b0;
  logic do_shift = 1'b0;
  logic [W-1:0] d_in = '0;
  logic [W-1:0] q;
  logic par_odd, all_zero;
  int total = 0;
  int bad = 0;
  logic [W-1:0] model = '0;

  always #4 clk = ~clk;

  shload_reg #(.WIDTH(W)) uut (.clk(clk), .clr_n(clr_n), .do_load(do_load),
    .do_shift(do_shift), .d_in(d_in), .q(q), .par_odd(par_odd), .all_zero(all_zero));

  function automatic logic ref_odd(logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) n += int'(v[i]);
    return (n % 2) == 1;
  endfunction

  task automatic check(string req, logic [W-1:0] exp);
    total++;
    if (q !== exp) begin bad++; $display("FAIL %s q act=%h exp=%h", req, q, exp); end
    total++;
    if (par_odd !== ref_odd(exp)) begin bad++;
      $display("FAIL R5 par_odd act=%b exp=%b", par_odd, ref_odd(exp)); end
    total++;
    if (all_zero !== (exp == '0)) begin bad++;
      $display("FAIL R6 all_zero act=%b exp=%b", all_zero, exp == '0); end
  endtask

  // Drive after falling edge, clock through rising edge, sample at next falling edge.
  task automatic step(logic ld, logic sh, logic [W-1:0] d);
    do_load = ld; do_shift = sh; d_in = d;
    @(negedge clk);
    if (sh) model = {model[W-2:0], 1'b0};
    else if (ld) model = d;
    do_load = 0; do_shift = 0;
  endtask

  task automatic t_load(logic [W-1:0] d);
    step(1, 0, d); check("R3", model);
  endtask

  task automatic t_hold();
    for (int i = 0; i < 3; i++) begin
      step(0, 0, {$urandom, $urandom}); check("R2_R7", model);
    end
  endtask

  task automatic t_shift(int n);
    for (int i = 0; i < n; i++) begin step(0, 1, '1); check("R4", model); end
  endtask

  task automatic t_clear();
    #1 clr_n = 0; #1;
    model = '0; check("R1", model);
    @(negedge clk); check("R1", model);
    clr_n = 1;
  endtask

  initial begin
    #1000000; bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad); $finish;
  end

  initial begin
    @(negedge clk); check("R1", '0);
    @(negedge clk); clr_n = 1;
    t_load('1);
    t_hold();
    t_load(64'h8000_0000_0000_0000);
    t_shift(1);
    t_load(64'h0000_0000_0000_0001);
    t_shift(64);
    t_load(64'hAAAA_AAAA_AAAA_AAAA);
    t_shift(2);
    t_load(64'h5555_5555_5555_5554);
    t_hold();
    for (int k = 0; k < 8; k++) begin t_load({$urandom, $urandom}); t_shift(3); end
    t_load(64'hDEAD_BEEF_0123_4567);
    t_clear();
    t_hold();
    t_load(64'h0000_0000_0000_0007);
    t_shift(62);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule